// File: doc/BRIEF.md
# Bit-Serial Lightweight Feistel Encryption Datapath

This block encrypts one 32-bit block under a 64-bit key with the lightweight SIMON32/64 cipher. The block is held as two 16-bit halves, and the datapath produces one bit of a new left half per clock, least significant bit first, over 32 rounds. A separate key schedule outside the block supplies the round keys one bit at a time. The block raises `key_rd` in each cycle in which it samples `key_bit` on the next rising edge.

The current left half sits in one of two ping-pong registers. That register rotates right once per cycle, so the three rotated copies that the nonlinear function needs are always at fixed bit positions. The other register collects the new left half as it is produced, and the two registers swap roles at every round boundary. An optional alignment delay of `BAL` registers (four by default) sits after the function and the transfer path. It stretches every round by `BAL` cycles, so that new bits reach the registers only from round cycle `BAL` on. This matches a key path that needs those extra cycles.

A `start` pulse loads the plaintext in parallel. `done` pulses when the ciphertext is ready, and the ciphertext then stays on `ct` until the next accepted start.

Top module: `simon_bs_core`

## Requirements
- R1: After reset, `busy`, `done` and `key_rd` are all 0.
- R2: `start` sampled high while `busy` is 0 loads `pt` (left half = pt[31:16], right half = pt[15:0]) and sets `busy` on that same edge. `busy` never rises without such a start.
- R3: With key words k0..k3 = 0100, 0908, 1110, 1918 (hex) and plaintext 6565_6877, `ct` reads c69b_e9bb when `done` pulses.
- R4: For any plaintext and key, every round maps (L, R) to (R ^ f(L) ^ K, L), where f(x) = (rotl(x,1) & rotl(x,8)) ^ rotl(x,2) on 16 bits. After 32 rounds `ct` = {L, R}.
- R5: `done` rises exactly ROUNDS*(WORD+BAL) clock edges after the edge that accepts `start` (640 with defaults), on the same edge at which `busy` falls.
- R6: In every round `key_rd` is high for exactly WORD consecutive cycles, starting BAL cycles after the round begins. Bit j of that round's key (LSB first) is sampled in the j-th of those cycles. An encryption takes ROUNDS*WORD key bits in total, and `key_rd` is never high while the block is idle.
- R7: `done` is high for exactly one cycle per encryption.
- R8: While the block is idle and no start arrives, `ct` holds its value.
- R9: A `start` received while `busy` is 1 is ignored. The running result, its latency and its key-bit count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an encryption of `pt` when idle |
| pt | input | 32 | Plaintext, left half in the upper 16 bits |
| key_bit | input | 1 | Serial round-key bit, sampled when `key_rd` is high |
| key_rd | output | 1 | The block samples `key_bit` on the next edge |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle pulse: ciphertext valid |
| ct | output | 32 | Ciphertext, left half in the upper 16 bits |

## Verification
The bench targets the wrap-around of the rotated taps at bit 0 and bit 15. A wrong tap position leaves the known-answer vector and the other plaintexts wrong after the first round, even if the lower bits happen to match. It checks the ping-pong swap at every round boundary, where a missing or early toggle would read the half that is being written and scramble the result. It checks the alignment of the key bits and the delayed transfer bits, where an off-by-one would shift the key stream by one bit, and the latency and key-bit counts, where an off-by-one would move `done`. A start issued mid-run must not reload the state. A design that honoured it would return the ciphertext of the wrong plaintext, or at the wrong time.

// File: rtl/simon_bs_pkg.sv
package simon_bs_pkg;
  // rotation amounts of the nonlinear function (left rotations)
  localparam int unsigned ROT_AND_A = 1;
  localparam int unsigned ROT_AND_B = 8;
  localparam int unsigned ROT_XOR   = 2;

  // In a register that rotates right once per cycle, the bit that sits at
  // position 0 in cycle c is x[c]. Bit x[c-s] then sits at position width-s.
  function automatic int unsigned tap_pos(int unsigned width, int unsigned rot);
    return width - rot;
  endfunction

  // one output bit of the nonlinear function from its three taps
  function automatic logic f_bit(logic a, logic b, logic c);
    return (a & b) ^ c;
  endfunction
endpackage

// File: rtl/simon_bs_ctrl.sv
module simon_bs_ctrl #(
  parameter int unsigned WORD   = 16,
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned BAL    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic rd_ph,
  output logic wr_ph,
  output logic rnd_end,
  output logic done
);
  localparam int unsigned RLEN = WORD + BAL;
  localparam int unsigned CW   = (RLEN > 1) ? $clog2(RLEN) : 1;
  localparam int unsigned RW   = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(RLEN - 1);
  localparam logic [RW-1:0] RND_LAST = RW'(ROUNDS - 1);

  logic [CW-1:0] cyc_q;
  logic [RW-1:0] rnd_q;
  logic          busy_q, done_q;

  assign accept  = start && !busy_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_ph   = busy_q && (int'(cyc_q) < int'(WORD));
  assign wr_ph   = busy_q && (int'(cyc_q) >= int'(BAL));
  assign rnd_end = busy_q && (cyc_q == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
        rnd_q  <= '0;
      end else if (busy_q) begin
        if (cyc_q == CYC_LAST) begin
          cyc_q <= '0;
          if (rnd_q == RND_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/simon_bs_delay.sv
module simon_bs_delay #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= din;
          for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/simon_bs_pingpong.sv
module simon_bs_pingpong #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_word,
  input  logic         rot,
  input  logic         wr,
  input  logic         wbit,
  input  logic         swap,
  output logic [W-1:0] rd_word
);
  logic [W-1:0] reg0_q, reg1_q, reg0_d, reg1_d;
  logic         sel_q;

  assign rd_word = sel_q ? reg1_q : reg0_q;

  // the register selected by sel_q is read and rotated; the other is written
  always_comb begin
    reg0_d = reg0_q;
    reg1_d = reg1_q;
    if (rot) begin
      if (!sel_q) reg0_d = {reg0_q[0], reg0_q[W-1:1]};
      else        reg1_d = {reg1_q[0], reg1_q[W-1:1]};
    end
    if (wr) begin
      if (!sel_q) reg1_d = {wbit, reg1_q[W-1:1]};
      else        reg0_d = {wbit, reg0_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg0_q <= '0;
      reg1_q <= '0;
      sel_q  <= 1'b0;
    end else if (load) begin
      reg0_q <= ld_word;
      reg1_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      reg0_q <= reg0_d;
      reg1_q <= reg1_d;
      if (swap) sel_q <= ~sel_q;
    end
  end
endmodule

// File: rtl/simon_bs_core.sv
module simon_bs_core #(
  parameter int unsigned WORD   = 16,
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned BAL    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2*WORD-1:0] pt,
  input  logic              key_bit,
  output logic              key_rd,
  output logic              busy,
  output logic              done,
  output logic [2*WORD-1:0] ct
);
  import simon_bs_pkg::*;

  localparam int unsigned TAP_A = tap_pos(WORD, ROT_AND_A);
  localparam int unsigned TAP_B = tap_pos(WORD, ROT_AND_B);
  localparam int unsigned TAP_C = tap_pos(WORD, ROT_XOR);

  logic            accept, rd_ph, wr_ph, rnd_end;
  logic [WORD-1:0] left_w, right_q;
  logic            cur_bit, fn_bit, cur_dly, fn_dly, new_bit;

  simon_bs_ctrl #(.WORD(WORD), .ROUNDS(ROUNDS), .BAL(BAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .rd_ph(rd_ph), .wr_ph(wr_ph), .rnd_end(rnd_end), .done(done)
  );

  // taps of the current left half
  assign cur_bit = left_w[0];
  assign fn_bit  = f_bit(left_w[TAP_A], left_w[TAP_B], left_w[TAP_C]);

  simon_bs_delay #(.W(2), .DEPTH(BAL)) u_align (
    .clk(clk), .rst_n(rst_n), .din({cur_bit, fn_bit}), .dout({cur_dly, fn_dly})
  );

  assign new_bit = right_q[0] ^ fn_dly ^ key_bit;
  assign key_rd  = wr_ph;

  simon_bs_pingpong #(.W(WORD)) u_left (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_word(pt[2*WORD-1:WORD]),
    .rot(rd_ph), .wr(wr_ph), .wbit(new_bit), .swap(rnd_end), .rd_word(left_w)
  );

  // right half: the old left half streams in while the old right streams out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      right_q <= '0;
    else if (accept) right_q <= pt[WORD-1:0];
    else if (wr_ph)  right_q <= {cur_dly, right_q[WORD-1:1]};
  end

  assign ct = {left_w, right_q};
endmodule

// File: rtl/simon_bs_chk.sv
module simon_bs_chk #(
  parameter int unsigned WORD   = 16,
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned BAL    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              key_rd,
  input logic              busy,
  input logic              done,
  input logic [2*WORD-1:0] ct
);
  localparam int unsigned RUN_LEN  = ROUNDS * (WORD + BAL);
  localparam int unsigned KEY_BITS = ROUNDS * WORD;

  int unsigned run_cnt, key_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= 0;
      key_cnt <= 0;
    end else if (start && !busy) begin
      run_cnt <= 0;
      key_cnt <= 0;
    end else begin
      if (busy)   run_cnt <= run_cnt + 1;
      if (key_rd) key_cnt <= key_cnt + 1;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R2
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R5
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) done |-> run_cnt == RUN_LEN); // R5
  AST_KEY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) key_rd |-> busy); // R6
  AST_KEY_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done |-> key_cnt == KEY_BITS); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(ct)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !done) |=> busy || done); // R9
endmodule

bind simon_bs_core simon_bs_chk #(.WORD(WORD), .ROUNDS(ROUNDS), .BAL(BAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_rd(key_rd),
  .busy(busy), .done(done), .ct(ct)
);

// File: tb/test_simon_bs_core.sv
module test_simon_bs_core;
  localparam int WORD = 16, ROUNDS = 32, BAL = 4;
  localparam int RUN = ROUNDS * (WORD + BAL);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, key_bit = 1'b0;
  logic [31:0] pt = '0;
  logic key_rd, busy, done;
  logic [31:0] ct;

  always #2 clk = ~clk; // 250 MHz

  simon_bs_core #(.WORD(WORD), .ROUNDS(ROUNDS), .BAL(BAL)) i_simon_bs_core (
    .clk(clk), .rst_n(rst_n), .start(start), .pt(pt), .key_bit(key_bit),
    .key_rd(key_rd), .busy(busy), .done(done), .ct(ct)
  );

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic        ks[ROUNDS*WORD];
  int kidx = 0, lat = -1000, first_key = -1, monitored = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rl(input logic [15:0] x, input int s);
    return (x << s) | (x >> (16 - s));
  endfunction

  // independent reference: key expansion plus round loop
  task automatic model(input logic [63:0] key, input logic [31:0] p, output logic [31:0] c);
    logic [61:0] z0 = 62'b11111010001001010110000111001101111101000100101011000011100110;
    logic [15:0] k[ROUNDS];
    logic [15:0] x, y, t, tmp;
    for (int i = 0; i < 4; i++) k[i] = key[16*i +: 16];
    for (int i = 4; i < ROUNDS; i++) begin
      tmp = rl(k[i-1], 13) ^ k[i-3];
      tmp = tmp ^ rl(tmp, 15);
      k[i] = 16'hfffc ^ {15'd0, z0[61 - ((i-4) % 62)]} ^ k[i-4] ^ tmp;
    end
    x = p[31:16];
    y = p[15:0];
    for (int r = 0; r < ROUNDS; r++) begin
      t = x;
      x = y ^ ((rl(x,1) & rl(x,8)) ^ rl(x,2)) ^ k[r];
      y = t;
    end
    c = {x, y};
    for (int r = 0; r < ROUNDS; r++)
      for (int j = 0; j < WORD; j++) ks[r*WORD + j] = k[r][j];
  endtask

  // driver: load the key stream, push the expected result, pulse start
  task automatic encrypt(input logic [63:0] key, input logic [31:0] p);
    logic [31:0] e;
    model(key, p, e);
    exp_q.push_back(e);
    @(negedge clk);
    kidx = 0;
    first_key = -1;
    pt = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // key feeder and latency/key-rate bookkeeping at the falling edge
  always @(negedge clk) begin
    if (start && !busy) lat = 0;
    if (key_rd) begin
      if (first_key < 0) first_key = lat;
      key_bit = ks[kidx];
      kidx++;
    end
  end
  always @(posedge clk) lat++;

  // monitor: pops the expected ciphertext when done is seen
  initial begin
    logic [31:0] e;
    forever begin
      @(negedge clk);
      if (done) begin
        e = exp_q.pop_front();
        check(ct === e, "R3/R4 ciphertext", ct, e);
        check(lat == RUN + 1, "R5 latency", lat, RUN + 1);               // R5
        check(kidx == ROUNDS*WORD, "R6 key bit count", kidx, ROUNDS*WORD); // R6
        check(first_key == BAL + 1, "R6 first key cycle", first_key, BAL + 1);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", done, 0);               // R7
        check(ct === e, "R8 ct held", ct, e);                            // R8
        monitored++;
      end
    end
  end

  task automatic wait_done(input int n);
    while (monitored < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [63:0] key_a = 64'h1918_1110_0908_0100;
    logic [63:0] key_b = 64'h0f1e_2d3c_4b5a_6978;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check({busy, done, key_rd} == 3'b000, "R1 reset state", {busy, done, key_rd}, 0); // R1
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, key_rd} == 3'b000, "R1 idle after reset", {busy, done, key_rd}, 0);

    // R3 known-answer vector
    encrypt(key_a, 32'h6565_6877);
    check(busy == 1'b1, "R2 busy after start", busy, 1); // R2
    wait_done(1);

    // R4 other patterns, wrap-around taps
    encrypt(key_a, 32'h0000_0000); wait_done(2);
    encrypt(key_a, 32'hffff_ffff); wait_done(3);
    encrypt(key_b, 32'h8001_7ffe); wait_done(4);

    // R8 hold over idle cycles
    held = ct;
    repeat (20) @(negedge clk);
    check(ct === held, "R8 idle hold", ct, held);
    check(key_rd == 1'b0, "R6 no key_rd idle", key_rd, 0);

    // R9 start while busy is ignored
    encrypt(key_b, 32'h1234_5678);
    repeat (100) @(negedge clk);
    pt = 32'hdead_beef;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 still busy", busy, 1);
    wait_done(5);
    check(exp_q.size() == 0, "R9 no extra result", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule